// File: doc/BRIEF.md
# Privileged Trap Sequencer with Countdown Timer

This block is the exception controller of a small pipelined processor whose program status word carries a privilege bit (P). It raises two kinds of trap. A privilege-violation trap fires when one of the two privileged opcodes is issued in user mode. A timeout trap fires when a free-running countdown timer has run out and an instruction retires in user mode. In supervisor mode (P = 1) privileged opcodes run normally and an expired timer never traps.

Both causes share one multi-cycle sequencer. It first requests a pipeline flush and waits until the flush is done. It then stores the current PSW and PC to two fixed memory words, reads a new PSW and a new PC from two more fixed words, and loads both into the processor in one cycle before control returns to fetch. Each cause has its own group of four vector words. The timer counts down once per clock from a preset value, stops at zero, and can be reloaded at any time through a load port. The datapath uses that port when it executes the timer-load opcode.

State machine: states IDLE, FLUSH, SAVE_PSW, SAVE_PC, LOAD_PSW, LOAD_PC and COMMIT. The transitions are:
- IDLE to FLUSH when either trap is pending.
- FLUSH to SAVE_PSW on `flush_done`.
- SAVE_PSW to SAVE_PC, SAVE_PC to LOAD_PSW, and LOAD_PSW to LOAD_PC, each on `mem_ready`.
- LOAD_PC to COMMIT on `mem_ready`.
- COMMIT to IDLE unconditionally.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the timer holds TMR_INIT and decreases by exactly one on every clock edge without a load.
- R2: The timer stops at zero and stays there until reloaded. `timer_zero` is high exactly when the count is zero.
- R3: When `tmr_load` is high at a clock edge, the count takes `tmr_value` at that edge. A load takes priority over the decrement.
- R4: A valid issue of opcode 14 or 15 with `priv` = 0 drives `op_suppress` high in the same cycle and leads to a privilege-violation trap. With `priv` = 1, or with any other opcode, there is no suppression and no trap.
- R5: A timeout trap starts only from a `boundary` strobe seen while the timer is zero and `priv` = 0. A boundary with a non-zero timer, or with `priv` = 1, starts nothing.
- R6: A trap sequence begins with `flush_req` held high until `flush_done` is seen. `busy` is high from the first cycle of `flush_req` through the commit cycle. At most one of `flush_req`, `mem_req` and `pc_load` is high in any cycle.
- R7: The memory accesses run in a fixed order, each with `mem_req` high, address and write enable held steady until `mem_ready`: write PSW to base+0, write PC to base+2, read PSW from base+4, read PC from base+6. The base is word 0 for a privilege violation and word 8 for a timeout. `mem_we` is 1 for the writes and 0 for the reads.
- R8: `pc_load` and `psw_load` are high together for exactly one cycle, immediately after the final read completes. `new_psw` and `new_pc` carry the two words that were read. Neither load is high earlier in the sequence.
- R9: When both causes become pending at the same edge, the privilege-violation sequence runs first and the timeout sequence follows it.
- R10: The PSW and PC written to memory are the `cur_psw` and `cur_pc` values sampled on the edge where the sequence leaves IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An opcode is being issued this cycle |
| issue_opcode | input | OPW | Decoded opcode being issued |
| priv | input | 1 | Privilege bit of the current PSW |
| boundary | input | 1 | Instruction retired, control returning to fetch |
| tmr_load | input | 1 | Load the timer this cycle |
| tmr_value | input | TW | New timer count |
| cur_pc | input | DW | Current program counter |
| cur_psw | input | DW | Current program status word |
| flush_done | input | 1 | Pipeline flush has completed |
| mem_ready | input | 1 | Memory accepts or answers the current access |
| mem_rdata | input | DW | Read data from memory |
| op_suppress | output | 1 | Issued privileged opcode must not execute |
| timer_count | output | TW | Current timer value |
| timer_zero | output | 1 | Timer has reached zero |
| flush_req | output | 1 | Pipeline flush request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| pc_load | output | 1 | Load `new_pc` into the PC |
| psw_load | output | 1 | Load `new_psw` into the PSW |
| new_pc | output | DW | Trap-handler PC |
| new_psw | output | DW | Trap-handler PSW |
| busy | output | 1 | Trap sequence in progress |

## Verification
A privilege violation and a timeout can arise in the same cycle. The bench provokes this by letting the timer run to zero, then issuing opcode 15 in user mode together with a `boundary` strobe. It judges the result by the vector addresses of two back-to-back sequences: words 0 to 6 must come first, then words 8 to 14, each sequence with its own commit of the handler PSW and PC. Timer loads are also placed in the same cycle as a would-be decrement, so that the load value must win.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_SAVE_PSW,
        ST_SAVE_PC,
        ST_LOAD_PSW,
        ST_LOAD_PC,
        ST_COMMIT
    } seq_state_t;

    typedef enum logic {
        CAUSE_PCHK,
        CAUSE_TMO
    } trap_cause_t;

    localparam int unsigned PRIV_OPC_A = 14;
    localparam int unsigned PRIV_OPC_B = 15;
    localparam logic [7:0]  PCHK_BASE  = 8'd0;
    localparam logic [7:0]  TMO_BASE   = 8'd8;

    function automatic logic [7:0] vec_word(trap_cause_t c, logic [1:0] step);
        logic [7:0] base;
        base = (c == CAUSE_TMO) ? TMO_BASE : PCHK_BASE;
        return base + {5'b0, step, 1'b0};
    endfunction

endpackage

// File: rtl/trap_timer.sv
module trap_timer #(
    parameter int unsigned TW       = 16,
    parameter int unsigned TMR_INIT = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic [TW-1:0] count,
    output logic          zero
);

    localparam logic [TW-1:0] INIT_V = TW'(TMR_INIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= INIT_V;
        end else if (load) begin
            count <= value;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);

    a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> (count == $past(count) - 1'b1));

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(value)));

endmodule

// File: rtl/trap_detect.sv
module trap_detect #(
    parameter int unsigned OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_valid,
    input  logic [OPW-1:0] issue_opcode,
    input  logic           priv,
    input  logic           boundary,
    input  logic           timer_zero,
    input  logic           clr_pchk,
    input  logic           clr_tmo,
    output logic           op_suppress,
    output logic           pend_pchk,
    output logic           pend_tmo
);
    import trap_pkg::*;

    logic is_priv_op;
    logic tmo_hit;

    assign is_priv_op  = (issue_opcode == OPW'(PRIV_OPC_A)) ||
                         (issue_opcode == OPW'(PRIV_OPC_B));
    assign op_suppress = issue_valid && is_priv_op && !priv;
    assign tmo_hit     = boundary && timer_zero && !priv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pchk <= 1'b0;
            pend_tmo  <= 1'b0;
        end else begin
            pend_pchk <= op_suppress || (pend_pchk && !clr_pchk);
            pend_tmo  <= tmo_hit     || (pend_tmo  && !clr_tmo);
        end
    end

    a_r4_suppress_pends: assert property (@(posedge clk) disable iff (!rst_n)
        op_suppress |=> pend_pchk);

    a_r5_timeout_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && timer_zero && !priv) |=> pend_tmo);

    a_r5_priv_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (priv && !pend_tmo) |=> !pend_tmo);

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_pchk,
    input  logic          pend_tmo,
    input  logic          flush_done,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] cur_pc,
    input  logic [DW-1:0] cur_psw,
    output logic          clr_pchk,
    output logic          clr_tmo,
    output logic          flush_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          pc_load,
    output logic          psw_load,
    output logic [DW-1:0] new_pc,
    output logic [DW-1:0] new_psw,
    output logic          busy
);
    import trap_pkg::*;

    seq_state_t  state, nxt;
    trap_cause_t cause_q;
    logic [DW-1:0] save_pc_q, save_psw_q, ld_pc_q, ld_psw_q;
    logic [1:0]    step;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (pend_pchk || pend_tmo) nxt = ST_FLUSH;
            ST_FLUSH:    if (flush_done) nxt = ST_SAVE_PSW;
            ST_SAVE_PSW: if (mem_ready)  nxt = ST_SAVE_PC;
            ST_SAVE_PC:  if (mem_ready)  nxt = ST_LOAD_PSW;
            ST_LOAD_PSW: if (mem_ready)  nxt = ST_LOAD_PC;
            ST_LOAD_PC:  if (mem_ready)  nxt = ST_COMMIT;
            ST_COMMIT:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // sequence data: cause, saved context, loaded vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q    <= CAUSE_PCHK;
            save_pc_q  <= '0;
            save_psw_q <= '0;
            ld_pc_q    <= '0;
            ld_psw_q   <= '0;
        end else begin
            if (state == ST_IDLE && (pend_pchk || pend_tmo)) begin
                cause_q    <= pend_pchk ? CAUSE_PCHK : CAUSE_TMO;
                save_pc_q  <= cur_pc;
                save_psw_q <= cur_psw;
            end
            if (state == ST_LOAD_PSW && mem_ready) ld_psw_q <= mem_rdata;
            if (state == ST_LOAD_PC  && mem_ready) ld_pc_q  <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        clr_pchk  = 1'b0;
        clr_tmo   = 1'b0;
        flush_req = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        psw_load  = 1'b0;
        busy      = 1'b1;
        step      = 2'd0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                clr_pchk = pend_pchk;
                clr_tmo  = pend_tmo && !pend_pchk;
            end
            ST_FLUSH: flush_req = 1'b1;
            ST_SAVE_PSW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = save_psw_q;
                step      = 2'd0;
            end
            ST_SAVE_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = save_pc_q;
                step      = 2'd1;
            end
            ST_LOAD_PSW: begin
                mem_req = 1'b1;
                step    = 2'd2;
            end
            ST_LOAD_PC: begin
                mem_req = 1'b1;
                step    = 2'd3;
            end
            ST_COMMIT: begin
                pc_load  = 1'b1;
                psw_load = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign mem_addr = {{(AW-8){1'b0}}, vec_word(cause_q, step)};
    assign new_pc   = ld_pc_q;
    assign new_psw  = ld_psw_q;

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r6_busy_starts_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> flush_req);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, mem_req, pc_load}));

    a_r8_commit_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(mem_req && !mem_we && mem_ready));

    a_r9_pchk_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pend_pchk) |=> (cause_q == CAUSE_PCHK));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
    parameter int unsigned OPW      = 4,
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned TW       = 16,
    parameter int unsigned TMR_INIT = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_valid,
    input  logic [OPW-1:0] issue_opcode,
    input  logic           priv,
    input  logic           boundary,
    input  logic           tmr_load,
    input  logic [TW-1:0]  tmr_value,
    input  logic [DW-1:0]  cur_pc,
    input  logic [DW-1:0]  cur_psw,
    input  logic           flush_done,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic           op_suppress,
    output logic [TW-1:0]  timer_count,
    output logic           timer_zero,
    output logic           flush_req,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           pc_load,
    output logic           psw_load,
    output logic [DW-1:0]  new_pc,
    output logic [DW-1:0]  new_psw,
    output logic           busy
);

    logic pend_pchk, pend_tmo, clr_pchk, clr_tmo;

    trap_timer #(.TW(TW), .TMR_INIT(TMR_INIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .value (tmr_value),
        .count (timer_count),
        .zero  (timer_zero)
    );

    trap_detect #(.OPW(OPW)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_opcode (issue_opcode),
        .priv         (priv),
        .boundary     (boundary),
        .timer_zero   (timer_zero),
        .clr_pchk     (clr_pchk),
        .clr_tmo      (clr_tmo),
        .op_suppress  (op_suppress),
        .pend_pchk    (pend_pchk),
        .pend_tmo     (pend_tmo)
    );

    trap_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_pchk  (pend_pchk),
        .pend_tmo   (pend_tmo),
        .flush_done (flush_done),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .cur_pc     (cur_pc),
        .cur_psw    (cur_psw),
        .clr_pchk   (clr_pchk),
        .clr_tmo    (clr_tmo),
        .flush_req  (flush_req),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .pc_load    (pc_load),
        .psw_load   (psw_load),
        .new_pc     (new_pc),
        .new_psw    (new_psw),
        .busy       (busy)
    );

endmodule

// File: tb/trap_sequencer_bench.sv
`timescale 1ns/1ps
module trap_sequencer_bench;

    localparam int INIT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [3:0]  issue_opcode = '0;
    logic        priv = 1'b0;
    logic        boundary = 1'b0;
    logic        tmr_load = 1'b0;
    logic [15:0] tmr_value = '0;
    logic [15:0] cur_pc = 16'h1234;
    logic [15:0] cur_psw = 16'h0040;
    logic        flush_done = 1'b0;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        op_suppress, timer_zero, flush_req, mem_req, mem_we;
    logic        pc_load, psw_load, busy;
    logic [15:0] timer_count, mem_addr, mem_wdata, new_pc, new_psw;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    trap_sequencer #(.TMR_INIT(INIT)) u_trap_sequencer (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
        .priv(priv), .boundary(boundary), .tmr_load(tmr_load), .tmr_value(tmr_value),
        .cur_pc(cur_pc), .cur_psw(cur_psw), .flush_done(flush_done), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .op_suppress(op_suppress), .timer_count(timer_count),
        .timer_zero(timer_zero), .flush_req(flush_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load), .psw_load(psw_load),
        .new_pc(new_pc), .new_psw(new_psw), .busy(busy)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle_quiet(input string tag);
        repeat (6) @(negedge clk);
        check(busy == 1'b0 && flush_req == 1'b0, tag, {31'b0, busy}, 32'h0);
    endtask

    // Serve one whole trap sequence and check every step of it.
    task automatic serve_trap(input logic [15:0] base, input logic [15:0] rpsw,
                              input logic [15:0] rpc, input string tag);
        int waited = 0;
        while (!flush_req && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(flush_req == 1'b1, {tag, " R6 flush_req raised"}, {31'b0, flush_req}, 32'h1);
        check(busy == 1'b1, {tag, " R6 busy with flush"}, {31'b0, busy}, 32'h1);
        @(negedge clk);
        check(flush_req == 1'b1 && mem_req == 1'b0, {tag, " R6 flush held"},
              {31'b0, flush_req}, 32'h1);
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] ea;
            ea = base + 16'(2 * i);
            check(mem_req == 1'b1, {tag, " R7 mem_req"}, {31'b0, mem_req}, 32'h1);
            check(mem_addr == ea, {tag, " R7 address"}, {16'b0, mem_addr}, {16'b0, ea});
            check(mem_we == (i < 2), {tag, " R7 write enable"}, {31'b0, mem_we}, (i < 2) ? 1 : 0);
            if (i == 0) check(mem_wdata == cur_psw, {tag, " R10 saved psw"},
                              {16'b0, mem_wdata}, {16'b0, cur_psw});
            if (i == 1) check(mem_wdata == cur_pc, {tag, " R10 saved pc"},
                              {16'b0, mem_wdata}, {16'b0, cur_pc});
            check(pc_load == 1'b0 && psw_load == 1'b0, {tag, " R8 no early load"},
                  {31'b0, pc_load}, 32'h0);
            if (i == 0) begin
                @(negedge clk);
                check(mem_req == 1'b1 && mem_addr == ea, {tag, " R7 held without ready"},
                      {16'b0, mem_addr}, {16'b0, ea});
            end
            mem_ready = 1'b1;
            mem_rdata = (i == 2) ? rpsw : (i == 3) ? rpc : 16'hdead;
            @(negedge clk);
            mem_ready = 1'b0;
        end
        check(pc_load == 1'b1 && psw_load == 1'b1, {tag, " R8 commit"},
              {30'b0, pc_load, psw_load}, 32'h3);
        check(new_pc == rpc, {tag, " R8 new_pc"}, {16'b0, new_pc}, {16'b0, rpc});
        check(new_psw == rpsw, {tag, " R8 new_psw"}, {16'b0, new_psw}, {16'b0, rpsw});
        check(busy == 1'b1, {tag, " R6 busy in commit"}, {31'b0, busy}, 32'h1);
        @(negedge clk);
        check(pc_load == 1'b0, {tag, " R8 single cycle load"}, {31'b0, pc_load}, 32'h0);
    endtask

    task automatic t_reset_timer;
        check(busy == 1'b0 && flush_req == 1'b0 && mem_req == 1'b0, "reset outputs idle",
              {29'b0, busy, flush_req, mem_req}, 32'h0);
        check(timer_count == 16'(INIT), "R1 reset count", {16'b0, timer_count}, INIT);
        repeat (3) @(negedge clk);
        check(timer_count == 16'(INIT - 3), "R1 count down", {16'b0, timer_count}, INIT - 3);
        repeat (INIT) @(negedge clk);
        check(timer_count == 16'd0 && timer_zero == 1'b1, "R2 stops at zero",
              {16'b0, timer_count}, 32'h0);
        idle_quiet("R5 zero timer without boundary");
    endtask

    task automatic t_reload;
        tmr_load = 1'b1;
        tmr_value = 16'd50;
        @(negedge clk);
        tmr_load = 1'b0;
        check(timer_count == 16'd50 && timer_zero == 1'b0, "R3 reload", {16'b0, timer_count}, 50);
        @(negedge clk);
        check(timer_count == 16'd49, "R1 after reload", {16'b0, timer_count}, 49);
    endtask

    task automatic t_priv_ops;
        priv = 1'b1;
        issue_valid = 1'b1;
        issue_opcode = 4'd15;
        #1 check(op_suppress == 1'b0, "R4 supervisor op15 runs", {31'b0, op_suppress}, 0);
        @(negedge clk);
        issue_valid = 1'b0;
        idle_quiet("R4 supervisor no trap");
        priv = 1'b0;
        issue_valid = 1'b1;
        issue_opcode = 4'd13;
        #1 check(op_suppress == 1'b0, "R4 user op13 runs", {31'b0, op_suppress}, 0);
        @(negedge clk);
        issue_valid = 1'b0;
        idle_quiet("R4 op13 no trap");
        issue_valid = 1'b1;
        issue_opcode = 4'd14;
        #1 check(op_suppress == 1'b1, "R4 user op14 suppressed", {31'b0, op_suppress}, 1);
        @(negedge clk);
        issue_valid = 1'b0;
        serve_trap(16'd0, 16'h8001, 16'h0300, "R4 pchk");
        idle_quiet("R6 back to idle");
    endtask

    task automatic t_timeout;
        tmr_load = 1'b1;
        tmr_value = 16'd40;
        @(negedge clk);
        tmr_load = 1'b0;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        idle_quiet("R5 nonzero timer no trap");
        tmr_load = 1'b1;
        tmr_value = 16'd2;
        @(negedge clk);
        tmr_load = 1'b0;
        repeat (4) @(negedge clk);
        check(timer_zero == 1'b1, "R2 zero before boundary", {31'b0, timer_zero}, 1);
        priv = 1'b1;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        idle_quiet("R5 supervisor masks timeout");
        priv = 1'b0;
        cur_pc = 16'h0abc;
        cur_psw = 16'h0011;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        serve_trap(16'd8, 16'h8002, 16'h0400, "R5 timeout");
    endtask

    task automatic t_both;
        cur_pc = 16'h0555;
        cur_psw = 16'h0022;
        issue_valid = 1'b1;
        issue_opcode = 4'd15;
        boundary = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        boundary = 1'b0;
        serve_trap(16'd0, 16'h8003, 16'h0500, "R9 first pchk");
        serve_trap(16'd8, 16'h8004, 16'h0600, "R9 then timeout");
        idle_quiet("R9 both served");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_timer();
        t_reload();
        t_priv_ops();
        t_timeout();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule